// File: doc/BRIEF.md
# Debounced Controller Presence Detector

This block decides whether a serial game controller is plugged in by watching the level of its data line while the line is idle. A pull-up keeps an empty port high. An attached controller drives the line low between polls. The poller samples the idle level just before it starts each read and hands that sample to this block. The block changes its presence state only after the new level has held for a fixed stretch of time. That time is counted in ticks of a 1 MHz time base, not in samples, because samples arrive at an unpredictable and much faster rate than the polls.

The block outputs a registered presence flag and a single-cycle pulse for each attach and each detach. It also gates the button word coming from the poller. While the port is empty, poll results are thrown away and the button output reads zero. When a detach is accepted, the block issues one report with every button released, so no press stays latched downstream.

Top module: `pad_presence_detect`

## Requirements
- R1: While reset is asserted and on the first cycles after its release, present_o, attach_o, detach_o and buttons_valid_o are 0 and buttons_o is all zero.
- R2: A cycle with sample_i high captures data_idle_i. A value of 1 means the port looks empty and 0 means it looks occupied. A captured value that disagrees with present_o arms the debounce timer, and a disagreeing sample while the timer is already armed does not restart it.
- R3: From the absent state, present_o rises DEBOUNCE_TICKS tick_i pulses after the first low sample, counting from the cycle after that sample, provided no high sample arrives in between.
- R4: From the present state, present_o falls DEBOUNCE_TICKS tick_i pulses after the first high sample, under the same counting rule, provided no low sample arrives in between.
- R5: A sample that agrees with present_o disarms the timer and restarts the count. This holds even when it arrives in the cycle of the final tick: the sample wins and the state does not change.
- R6: attach_o pulses for exactly the cycle in which present_o is first 1. detach_o pulses for exactly the cycle in which present_o is first 0. The two are never high together.
- R7: While present_o is 1, a poll_valid_i cycle loads poll_buttons_i into buttons_o. buttons_valid_o is high in the following cycle.
- R8: When a detach is accepted, buttons_o becomes all zero and buttons_valid_o pulses once in the same cycle as detach_o. A poll result offered in the cycle that the detach is decided is discarded.
- R9: While present_o is 0, poll_valid_i has no effect: buttons_o stays zero and buttons_valid_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle strobe of the 1 MHz time base |
| sample_i | input | 1 | Strobe: idle level of the data line is valid |
| data_idle_i | input | 1 | Idle level of the data line (1 empty, 0 occupied) |
| poll_valid_i | input | 1 | Strobe: a poll result is on poll_buttons_i |
| poll_buttons_i | input | NBTN | Button word from the poller, 1 = pressed |
| present_o | output | 1 | Debounced presence state |
| attach_o | output | 1 | One-cycle pulse when presence is accepted |
| detach_o | output | 1 | One-cycle pulse when absence is accepted |
| buttons_o | output | NBTN | Gated button word, zero while absent |
| buttons_valid_o | output | 1 | One-cycle pulse when buttons_o carries a new report |

## Verification
Two pairs of events can land in the same cycle. In the first pair, a sample that agrees with the current state meets the tick that would end the debounce. In the second, a poll result meets the cycle that decides a detach. Directed sequences place an agreeing sample exactly on the final tick, and a poll result exactly on the deciding tick. The outputs are then judged against a cycle model in the bench: the sample must cancel the change, and the cleared report must replace the poll data. Random phases with long level holds and short glitches reach both collisions again from many timer offsets.

// File: rtl/pdd_pkg.sv
package pdd_pkg;
  typedef enum logic {
    LINK_ABSENT  = 1'b0,
    LINK_PRESENT = 1'b1
  } link_e;

  function automatic int cnt_width(input int limit);
    return (limit > 2) ? $clog2(limit) : 1;
  endfunction
endpackage

// File: rtl/pdd_timer.sv
module pdd_timer #(
  parameter int LIMIT = 500000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic due_o
);
  localparam int CW = pdd_pkg::cnt_width(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign due_o = run_i && tick_i && (cnt_q == LAST);

  always_comb begin
    cnt_en = !run_i || tick_i;
    if (!run_i)             cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R5: elapsed count stays inside the window
  a_r5_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R5: a disarmed timer always restarts from zero
  a_r5_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pdd_state.sv
module pdd_state
  import pdd_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_i,
  input  logic data_idle_i,
  input  logic due_i,
  output logic run_o,
  output logic present_o,
  output logic attach_o,
  output logic detach_o,
  output logic detach_now_o
);
  link_e link_q, link_d;
  logic  arm_q, arm_d;
  logic  att_q, det_q;
  logic  agree, differ, flip;

  // idle low means occupied
  assign agree  = sample_i && (data_idle_i == (link_q == LINK_ABSENT));
  assign differ = sample_i && !agree;
  assign flip   = due_i && !agree;
  assign run_o  = arm_q;
  assign detach_now_o = flip && (link_q == LINK_PRESENT);

  always_comb begin
    link_d = link_q;
    arm_d  = arm_q;
    if (flip) begin
      link_d = (link_q == LINK_PRESENT) ? LINK_ABSENT : LINK_PRESENT;
      arm_d  = 1'b0;
    end else if (agree) begin
      arm_d  = 1'b0;
    end else if (differ) begin
      arm_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      link_q <= LINK_ABSENT;
      arm_q  <= 1'b0;
      att_q  <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      link_q <= link_d;
      arm_q  <= arm_d;
      att_q  <= flip && (link_q == LINK_ABSENT);
      det_q  <= flip && (link_q == LINK_PRESENT);
    end
  end

  assign present_o = (link_q == LINK_PRESENT);
  assign attach_o  = att_q;
  assign detach_o  = det_q;

  a_r6_rise_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(present_o) |-> attach_o);
  a_r6_fall_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(present_o) |-> detach_o);
  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(attach_o && detach_o));
  a_r5_agree_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    agree |=> $stable(present_o));
  a_r2_no_change_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !arm_q |=> $stable(present_o));
endmodule

// File: rtl/pdd_report.sv
module pdd_report #(
  parameter int NBTN = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            present_i,
  input  logic            detach_now_i,
  input  logic            poll_valid_i,
  input  logic [NBTN-1:0] poll_buttons_i,
  output logic [NBTN-1:0] buttons_o,
  output logic            valid_o
);
  logic [NBTN-1:0] btn_q, btn_d;
  logic            vld_q, vld_d, btn_en;

  always_comb begin
    btn_en = 1'b0;
    btn_d  = btn_q;
    vld_d  = 1'b0;
    if (detach_now_i) begin
      btn_en = 1'b1;
      btn_d  = '0;
      vld_d  = 1'b1;
    end else if (poll_valid_i && present_i) begin
      btn_en = 1'b1;
      btn_d  = poll_buttons_i;
      vld_d  = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      btn_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (btn_en) btn_q <= btn_d;
    end
  end

  assign buttons_o = btn_q;
  assign valid_o   = vld_q;

  // R8: cleared report follows every accepted detach
  a_r8_clear_report: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detach_now_i |=> valid_o && (buttons_o == '0));
  // R9: polls while absent leave no trace
  a_r9_drop_absent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !present_i && !detach_now_i |=> !valid_o && $stable(buttons_o));
  // R7: accepted poll shows up one cycle later
  a_r7_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    present_i && poll_valid_i && !detach_now_i |=> valid_o && buttons_o == $past(poll_buttons_i));
endmodule

// File: rtl/pad_presence_detect.sv
module pad_presence_detect #(
  parameter int DEBOUNCE_TICKS = 500000,
  parameter int NBTN           = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            sample_i,
  input  logic            data_idle_i,
  input  logic            poll_valid_i,
  input  logic [NBTN-1:0] poll_buttons_i,
  output logic            present_o,
  output logic            attach_o,
  output logic            detach_o,
  output logic [NBTN-1:0] buttons_o,
  output logic            buttons_valid_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       run, due, detach_now;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  pdd_timer #(.LIMIT(DEBOUNCE_TICKS)) timer_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .run_i  (run),
    .tick_i (tick_i),
    .due_o  (due)
  );

  pdd_state state_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .sample_i     (sample_i),
    .data_idle_i  (data_idle_i),
    .due_i        (due),
    .run_o        (run),
    .present_o    (present_o),
    .attach_o     (attach_o),
    .detach_o     (detach_o),
    .detach_now_o (detach_now)
  );

  pdd_report #(.NBTN(NBTN)) report_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_n),
    .present_i      (present_o),
    .detach_now_i   (detach_now),
    .poll_valid_i   (poll_valid_i),
    .poll_buttons_i (poll_buttons_i),
    .buttons_o      (buttons_o),
    .valid_o        (buttons_valid_o)
  );

  // R9: gated word is zero whenever the port is empty
  a_r9_zero_absent: assert property (@(posedge clk_i) disable iff (!rst_n)
    !present_o |-> buttons_o == '0);
endmodule

// File: tb/pad_presence_detect_tb_top.sv
module pad_presence_detect_tb_top;
  localparam int L = 16;
  localparam int NB = 8;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic tick_i, sample_i, data_idle_i, poll_valid_i;
  logic [NB-1:0] poll_buttons_i;
  logic present_o, attach_o, detach_o, buttons_valid_o;
  logic [NB-1:0] buttons_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // bench reference state
  bit m_present, m_pend, m_att, m_det, m_vld;
  int m_cnt;
  logic [NB-1:0] m_btn;

  always #10 clk_i = ~clk_i;

  pad_presence_detect #(.DEBOUNCE_TICKS(L), .NBTN(NB)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .sample_i(sample_i),
    .data_idle_i(data_idle_i), .poll_valid_i(poll_valid_i),
    .poll_buttons_i(poll_buttons_i), .present_o(present_o),
    .attach_o(attach_o), .detach_o(detach_o), .buttons_o(buttons_o),
    .buttons_valid_o(buttons_valid_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit agrees(input bit samp, input bit lvl);
    return samp && (lvl == !m_present);
  endfunction

  task automatic step(input string tag, input bit tk, input bit samp,
                      input bit lvl, input bit pv, input logic [NB-1:0] pb);
    bit ag, flip, det_now;
    @(negedge clk_i);
    tick_i = tk; sample_i = samp; data_idle_i = lvl;
    poll_valid_i = pv; poll_buttons_i = pb;
    ag = agrees(samp, lvl);
    flip = m_pend && tk && (m_cnt == L - 1) && !ag;
    det_now = flip && m_present;
    m_att = flip && !m_present;
    m_det = det_now;
    if (!m_pend)     m_cnt = 0;
    else if (tk)     m_cnt = (m_cnt == L - 1) ? 0 : m_cnt + 1;
    if (flip)        m_pend = 0;
    else if (ag)     m_pend = 0;
    else if (samp)   m_pend = 1;
    m_vld = 0;
    if (det_now) begin
      m_btn = '0; m_vld = 1;
    end else if (pv && m_present) begin
      m_btn = pb; m_vld = 1;
    end
    if (flip) m_present = !m_present;
    @(posedge clk_i);
    #1;
    chk({tag, " present"}, present_o, m_present);
    chk("R6 attach", attach_o, m_att);
    chk("R6 detach", detach_o, m_det);
    chk("R7/R8/R9 buttons", buttons_o, m_btn);
    chk("R7/R8/R9 valid", buttons_valid_o, m_vld);
  endtask

  task automatic run_ticks(input string tag, input int n);
    for (int i = 0; i < n; i++) step(tag, 1, 0, 0, 0, '0);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit lvl;
    bit ln;
    void'($urandom(32'h5eed_0042));
    rst_ni = 0; tick_i = 0; sample_i = 0; data_idle_i = 1;
    poll_valid_i = 0; poll_buttons_i = '0;
    m_present = 0; m_pend = 0; m_cnt = 0; m_btn = '0;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 present in reset", present_o, 0);
    chk("R1 buttons in reset", buttons_o, 0);
    @(negedge clk_i); rst_ni = 1;
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 present after release", present_o, 0);
    chk("R1 valid after release", buttons_valid_o, 0);

    // R9: poll while absent is dropped
    step("R9", 0, 0, 0, 1, 8'hA5);
    // R2/R5: low sample arms, agreeing high on the final tick cancels
    step("R2", 0, 1, 0, 0, '0);
    run_ticks("R3", L - 1);
    step("R5", 1, 1, 1, 0, '0);
    chk("R5 stays absent", present_o, 0);
    // R3: low held through the full window attaches
    step("R2", 0, 1, 0, 0, '0);
    run_ticks("R3", L - 1);
    step("R3", 0, 1, 0, 0, '0); // repeated disagreeing sample keeps counting
    step("R3", 1, 0, 0, 0, '0);
    chk("R3 attached", present_o, 1);
    chk("R6 attach pulse", attach_o, 1);
    // R7: polls while present
    step("R7", 0, 0, 0, 1, 8'h3C);
    chk("R7 buttons loaded", buttons_o, 8'h3C);
    step("R7", 0, 0, 0, 1, 8'h81);
    // R4 + R8: high held, poll offered on the deciding tick
    step("R4", 0, 1, 1, 0, '0);
    run_ticks("R4", L - 1);
    step("R8", 1, 0, 1, 1, 8'hFF);
    chk("R8 cleared report", buttons_o, 0);
    chk("R8 report pulse", buttons_valid_o, 1);
    chk("R4 detached", present_o, 0);
    step("R9", 0, 0, 0, 1, 8'h77);

    // random phase: long holds with glitches
    lvl = 1;
    for (int c = 0; c < 6000; c++) begin
      bit tk, sm, pv;
      if ($urandom_range(299) == 0) lvl = !lvl;
      ln = lvl;
      if ($urandom_range(39) == 0) ln = !lvl;
      tk = (c % 4 == 0);
      sm = ($urandom_range(2) == 0);
      pv = ($urandom_range(4) == 0);
      step("R3/R4", tk, sm, ln, pv, NB'($urandom));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule